// File: doc/BRIEF.md
# Halted-Core Coprocessor Access Gate

This block decides whether a coprocessor register access that an external debugger issues to a halted core may proceed. Each request names its target: the debug coprocessor or the system-control coprocessor. It also carries the direction and two attributes of the addressed register. One attribute says whether the register has a separate copy for each security world. The other says whether non-secure code may only read it. The block combines the request with the core's security world, its processor mode, the non-secure select bit and the secure privileged debug enable. One cycle later it answers with a grant or a refusal and with the register copy that the access reaches.

The rights do not come from the mode the core happens to be halted in. They come from whether the debugger could legally move the core into a privileged mode of its current world. In the non-secure world that move is always open. In the secure world it is open only when secure privileged debug is enabled. A granted access then has the rights of a privileged mode of that world. A refused access produces a one-cycle undefined-exception pulse and sets a sticky undefined flag of the debug status. The flag holds until the debugger clears it.

The secure user-mode debug enable only decides whether the core can halt in secure user mode at all. It never widens register access, so it is not an input here. A core halted in secure user mode without secure privileged debug is refused all system-control access.

Top module: `dbg_cp_gate`

## Requirements
- R1: A request with `req_target` = 0 (debug coprocessor) is always granted, whatever the enable, world, mode, direction and attributes.
- R2: A system-control request (`req_target` = 1) made while the core is in the non-secure world (`world_ns` = 1) and not in monitor mode is granted, and `rsp_bank_ns` = 1. Reads are granted always. Writes are granted except in the case R3 describes. This holds whatever `sec_priv_en` is.
- R3: In the situation of R2, a write (`req_write` = 1) to a register that is unbanked (`reg_banked` = 0) and read-only to non-secure code (`reg_ns_ro` = 1) is refused. A read of the same register, and a write to a banked register, are granted.
- R4: A system-control request made in the secure world (`world_ns` = 0, or monitor mode) with `sec_priv_en` = 1 is granted for reads and writes, whatever the attributes. In user and other privileged modes it reaches the secure copy (`rsp_bank_ns` = 0).
- R5: A system-control request made in the secure world with `sec_priv_en` = 0 is refused in every mode, secure user mode included. So a granted system-control access with `sec_priv_en` = 0 always has `rsp_bank_ns` = 1.
- R6: `cpu_mode` encodes 0 = user, 1 = privileged, 2 = monitor and 3 = another privileged mode. Monitor mode counts as the secure world whatever `world_ns` is. In monitor mode `rsp_bank_ns` equals `ns_bit`.
- R7: A request with `req_valid` high in cycle N gives `rsp_valid` = 1 together with its `rsp_ok` and `rsp_bank_ns` in cycle N+1. A cycle without a request gives `rsp_valid`, `rsp_ok`, `rsp_bank_ns` and `undef_pulse` all 0 in the next cycle.
- R8: `undef_pulse` is high for exactly the one response cycle of each refused request, and it is low for every granted one.
- R9: `undef_sticky` rises in the cycle of the pulse that sets it. It then holds until a cycle in which `undef_clr` is sampled high with no refused request, and it is low from the next cycle on. A clear and a refusal sampled in the same cycle leave it set.
- R10: After synchronous reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present this cycle |
| req_target | input | 1 | 0 = debug coprocessor, 1 = system-control coprocessor |
| req_write | input | 1 | 1 = write, 0 = read |
| reg_banked | input | 1 | Addressed register has a copy per security world |
| reg_ns_ro | input | 1 | Addressed register or bits are read-only to non-secure code |
| sec_priv_en | input | 1 | Secure privileged debug enabled |
| world_ns | input | 1 | Core halted in the non-secure world |
| cpu_mode | input | 2 | Halted mode: 0 user, 1 privileged, 2 monitor, 3 other privileged |
| ns_bit | input | 1 | Non-secure select bit, picks the copy in monitor mode |
| undef_clr | input | 1 | Clears the sticky undefined flag |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Access granted |
| rsp_bank_ns | output | 1 | 1 = non-secure copy, 0 = secure copy |
| undef_pulse | output | 1 | One-cycle undefined exception for a refused access |
| undef_sticky | output | 1 | Sticky undefined flag |

## Verification
The assertions assume that the world, mode, enable and attribute inputs stay stable within the cycle in which they are sampled. They also assume that the clear input is an ordinary level that may coincide with a refusal. They do not assume that only reachable combinations occur, such as monitor mode with `world_ns` set, because R6 defines that case. The stimulus sweeps every combination of the request and core-state inputs back to back with the clear held high. Each response therefore shows the flag following only its own refusal. Dedicated idle cycles then show the flag holding and clearing with no request present.

// File: rtl/dbg_cp_gate_pkg.sv
package dbg_cp_gate_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MD_USER  = 2'd0,
    MD_PRIV  = 2'd1,
    MD_MON   = 2'd2,
    MD_PRIV2 = 2'd3
  } cpu_mode_e;

  typedef enum logic {
    TGT_DBG = 1'b0,
    TGT_SYS = 1'b1
  } cp_target_e;

  typedef struct packed {
    logic in_secure;
    logic bank_ns;
    logic may_raise;
  } world_view_t;

endpackage

// File: rtl/dbg_world_eval.sv
module dbg_world_eval
  import dbg_cp_gate_pkg::*;
(
  input  logic              world_ns,
  input  logic [MODE_W-1:0] cpu_mode,
  input  logic              ns_bit,
  input  logic              sec_priv_en,
  output world_view_t       view
);

  logic is_mon;

  always_comb begin
    is_mon         = (cpu_mode_e'(cpu_mode) == MD_MON);
    view.in_secure = is_mon | ~world_ns;
    // privileged entry within the current world: always open when non-secure
    view.may_raise = view.in_secure ? sec_priv_en : 1'b1;
    view.bank_ns   = is_mon ? ns_bit : ~view.in_secure;
  end

  always_comb begin
    if (is_mon) assert_mon_secure_R6: assert (view.in_secure);
  end

endmodule

// File: rtl/dbg_access_rule.sv
module dbg_access_rule
  import dbg_cp_gate_pkg::*;
(
  input  logic        req_target,
  input  logic        req_write,
  input  logic        reg_banked,
  input  logic        reg_ns_ro,
  input  world_view_t view,
  output logic        grant
);

  logic ro_block;

  always_comb begin
    ro_block = ~view.in_secure & req_write & ~reg_banked & reg_ns_ro;
    unique case (cp_target_e'(req_target))
      TGT_DBG: grant = 1'b1;
      TGT_SYS: grant = view.may_raise & ~ro_block;
      default: grant = 1'b0;
    endcase
  end

  always_comb begin
    if (cp_target_e'(req_target) == TGT_DBG) assert_dbg_free_R1: assert (grant);
  end

endmodule

// File: rtl/dbg_sticky_flag.sv
module dbg_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  always_ff @(posedge clk) begin
    if (rst) flag_o <= 1'b0;
    else     flag_o <= set_i | (flag_o & ~clr_i);
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    flag_o && !clr_i |=> flag_o);

endmodule

// File: rtl/dbg_cp_gate.sv
module dbg_cp_gate
  import dbg_cp_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_target,
  input  logic       req_write,
  input  logic       reg_banked,
  input  logic       reg_ns_ro,
  input  logic       sec_priv_en,
  input  logic       world_ns,
  input  logic [1:0] cpu_mode,
  input  logic       ns_bit,
  input  logic       undef_clr,
  output logic       rsp_valid,
  output logic       rsp_ok,
  output logic       rsp_bank_ns,
  output logic       undef_pulse,
  output logic       undef_sticky
);

  world_view_t view;
  logic        grant;
  logic        refuse;

  dbg_world_eval u_world (
    .world_ns    (world_ns),
    .cpu_mode    (cpu_mode),
    .ns_bit      (ns_bit),
    .sec_priv_en (sec_priv_en),
    .view        (view)
  );

  dbg_access_rule u_rule (
    .req_target (req_target),
    .req_write  (req_write),
    .reg_banked (reg_banked),
    .reg_ns_ro  (reg_ns_ro),
    .view       (view),
    .grant      (grant)
  );

  assign refuse = req_valid & ~grant;

  dbg_sticky_flag u_sticky (
    .clk    (clk),
    .rst    (rst),
    .set_i  (refuse),
    .clr_i  (undef_clr),
    .flag_o (undef_sticky)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_ok      <= 1'b0;
      rsp_bank_ns <= 1'b0;
      undef_pulse <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_ok      <= req_valid & grant;
      rsp_bank_ns <= req_valid & view.bank_ns;
      undef_pulse <= refuse;
    end
  end

  assert_dbg_open_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_target |=> rsp_ok && !undef_pulse);

  assert_ns_bank_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_target && world_ns && cpu_mode != 2'd2 |=> rsp_bank_ns);

  assert_ns_ro_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_target && world_ns && cpu_mode != 2'd2 && req_write
    && !reg_banked && reg_ns_ro |=> !rsp_ok && undef_pulse);

  assert_no_sec_bank_R5: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_target && !sec_priv_en |=> !rsp_ok || rsp_bank_ns);

  assert_mon_bank_R6: assert property (@(posedge clk) disable iff (rst)
    req_valid && cpu_mode == 2'd2 |=> rsp_bank_ns == $past(ns_bit));

  assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && !rsp_ok && !undef_pulse);

  assert_pulse_flag_R8: assert property (@(posedge clk) disable iff (rst)
    undef_pulse |-> undef_sticky && rsp_valid && !rsp_ok);

endmodule

// File: tb/dbg_cp_gate_test.sv
`timescale 1ns/1ps
module dbg_cp_gate_test;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_target, req_write, reg_banked, reg_ns_ro;
  logic sec_priv_en, world_ns, ns_bit, undef_clr;
  logic [1:0] cpu_mode;
  logic rsp_valid, rsp_ok, rsp_bank_ns, undef_pulse, undef_sticky;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  dbg_cp_gate uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_target(req_target),
    .req_write(req_write), .reg_banked(reg_banked), .reg_ns_ro(reg_ns_ro),
    .sec_priv_en(sec_priv_en), .world_ns(world_ns), .cpu_mode(cpu_mode),
    .ns_bit(ns_bit), .undef_clr(undef_clr), .rsp_valid(rsp_valid),
    .rsp_ok(rsp_ok), .rsp_bank_ns(rsp_bank_ns), .undef_pulse(undef_pulse),
    .undef_sticky(undef_sticky)
  );

  task automatic check5(input string req, input logic [4:0] act, input logic [4:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {valid,ok,bank,pulse,sticky} actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic string tag_of(input bit tgt, input bit sec, input bit mon, input bit ok);
    if (!tgt)     return "R1";
    if (mon)      return "R6";
    if (sec)      return ok ? "R4" : "R5";
    return ok ? "R2" : "R3";
  endfunction

  initial begin
    #(1_000_000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 0; req_target = 0; req_write = 0; reg_banked = 0;
    reg_ns_ro = 0; sec_priv_en = 0; world_ns = 0; cpu_mode = 0; ns_bit = 0;
    undef_clr = 0;
    repeat (3) @(negedge clk);
    check5("R10 reset", {rsp_valid, rsp_ok, rsp_bank_ns, undef_pulse, undef_sticky}, 5'b0);
    rst = 1'b0;

    // exhaustive sweep, clear held high so the flag follows each response
    for (int i = 0; i < 1024; i++) begin
      bit spe, wns, nsb, tgt, wr, bk, ro, mon, sec, bank, ok;
      logic [1:0] md;
      {spe, wns, nsb, tgt, wr, bk, ro} = i[6:0];
      md  = i[8:7];
      mon = (md == 2'd2);
      sec = mon || !wns;
      bank = mon ? nsb : !sec;
      if (!tgt)     ok = 1'b1;
      else if (sec) ok = spe;
      else          ok = !(wr && !bk && ro);
      req_valid = 1; req_target = tgt; req_write = wr; reg_banked = bk;
      reg_ns_ro = ro; sec_priv_en = spe; world_ns = wns; cpu_mode = md;
      ns_bit = nsb; undef_clr = (i[9] == 1'b0);
      @(negedge clk);
      if (i[9] == 1'b0)
        check5({tag_of(tgt, sec, mon, ok), " R7 R8 R9"},
               {rsp_valid, rsp_ok, rsp_bank_ns, undef_pulse, undef_sticky},
               {1'b1, ok, bank, !ok, !ok});
      else
        check5({tag_of(tgt, sec, mon, ok), " R7 R8"},
               {rsp_valid, rsp_ok, rsp_bank_ns, undef_pulse},
               {1'b1, ok, bank, !ok});
    end

    // refusal with clear low: flag set
    req_valid = 1; req_target = 1; sec_priv_en = 0; world_ns = 0; cpu_mode = 0;
    undef_clr = 0;
    @(negedge clk);
    check5("R5 R9 secure user refused", {rsp_valid, rsp_ok, rsp_bank_ns, undef_pulse, undef_sticky}, 5'b10011);
    // idle cycle, flag holds, nothing else
    req_valid = 0;
    @(negedge clk);
    check5("R7 R9 idle hold", {rsp_valid, rsp_ok, rsp_bank_ns, undef_pulse, undef_sticky}, 5'b00001);
    // granted request does not clear
    req_valid = 1; req_target = 0;
    @(negedge clk);
    check5("R1 R9 grant keeps flag", {rsp_valid, rsp_ok, rsp_bank_ns, undef_pulse, undef_sticky}, 5'b11001);
    // clear and refusal together: stays set
    req_target = 1; undef_clr = 1;
    @(negedge clk);
    check5("R9 clear with fault", {rsp_valid, rsp_ok, rsp_bank_ns, undef_pulse, undef_sticky}, 5'b10011);
    // clear alone
    req_valid = 0;
    @(negedge clk);
    check5("R9 clear alone", {rsp_valid, rsp_ok, rsp_bank_ns, undef_pulse, undef_sticky}, 5'b00000);
    undef_clr = 0;
    @(negedge clk);
    check5("R9 stays clear", {rsp_valid, rsp_ok, rsp_bank_ns, undef_pulse, undef_sticky}, 5'b00000);
    // reset mid-run after a refusal
    req_valid = 1;
    @(negedge clk);
    rst = 1; req_valid = 0;
    @(negedge clk);
    check5("R10 reset after fault", {rsp_valid, rsp_ok, rsp_bank_ns, undef_pulse, undef_sticky}, 5'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule